// File: doc/BRIEF.md
# SDRAM Controller Configuration Register File

This block holds the configuration and status registers of an SDRAM controller. Software reaches them in two steps through a pair of register numbers on a simple register bus. First it writes an internal offset to the index port. Then it reads or writes the data port, and that access lands on the register the offset selects. Each register keeps only its writable bits, with fixed bits forced where the register defines them. The block also tracks the controller enable and self-refresh request bits of the configuration register in a read-only status register.

The block also holds two error status registers. The memory controller sets their bits through pulse inputs, and software clears them by writing a one to each bit. An ECC error status register drives a level interrupt. A per-bank "active" output tells the address decoder which banks are mapped: a bank is mapped when its enable bit is set and the controller is enabled. SDRAM command sequencing and the data path are not part of this block.

Top module: `sdrc_cfg_regs`

## Requirements
- R1: After reset, the data port reads the following values. Configuration (offset 0x20) is 0x00800000, refresh (0x30) is 0x05F00000, power-management timer (0x34) is 0x07C00000 and timing (0x80) is 0x00854009. Every other register reads 0. `bank_active` and `ecc_irq` are 0.
- R2: A write to the index port (register number 0x010) stores the full 32-bit offset. A read of the index port returns the last offset written.
- R3: Data-port writes keep only the writable bits of each register. The masks are 0x3FF80000 for refresh (0x30), 0x018FC01F for timing (0x80), 0x00F00000 for ECC configuration (0x94) and 0xFFDEE001 for bank n (offset 0x40+4n). The error address (0x10), configuration (0x20) and ECC error status (0x98) registers store all 32 bits.
- R4: A write to the power-management timer stores (value AND 0xF8000000) OR 0x07C00000.
- R5: The error status registers sit at offsets 0x00 and 0x08. A data-port write clears every bit written as 1. Inputs `err_set0` and `err_set1` set bits in the clock after they are seen. A set and a clear of the same bit in the same cycle leave the bit set.
- R6: The status register (0x24) is read-only. Data-port writes to it leave it unchanged.
- R7: When a configuration write takes bit 31 from 0 to 1, status bit 31 clears. When a write takes bit 31 from 1 to 0, status bit 31 sets.
- R8: When a configuration write takes bit 30 from 0 to 1, status bit 30 sets. When a write takes bit 30 from 1 to 0, status bit 30 clears.
- R9: `ecc_irq` is high exactly while the ECC error status register is nonzero. It rises on the clock edge of a write that makes the register nonzero and falls on the edge of a write that makes it zero.
- R10: Offsets that name no register read as 0. Writes to them change no register.
- R11: `bank_active[n]` is high when configuration bit 31 and bit 0 of bank register n are both 1, and low otherwise.
- R12: A read of the index or data port returns its data on `bus_rdata` with `bus_rvalid` high in the cycle after `bus_rd`. Accesses to any other register number return no `bus_rvalid` and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_num | input | NUM_W | Register number of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| err_set0 | input | 32 | Bit-set pulses for error status 0 |
| err_set1 | input | 32 | Bit-set pulses for error status 1 |
| bank_active | output | N_BANKS | Bank mapped (enabled and controller on) |
| ecc_irq | output | 1 | ECC error interrupt, registered |

## Verification
Every register write takes effect at the clock edge that samples `bus_wr`. The same holds for the status bits, `ecc_irq` and `bank_active`, so all of them are due one edge after the write. A read is sampled one edge later, so its data is due in the cycle after `bus_rd`. The bench drives on the falling edge and checks on the following falling edge. It therefore always looks after exactly one rising edge, and ties each check to the cycle in which that result is due. Error-set pulses are likewise checked one edge after the pulse, through a later data-port read.

// File: rtl/sdrc_pkg.sv
package sdrc_pkg;
  localparam int DW = 32;

  // internal offsets selected by the index port
  localparam logic [DW-1:0] OFS_ERR0  = 32'h00;
  localparam logic [DW-1:0] OFS_ERR1  = 32'h08;
  localparam logic [DW-1:0] OFS_EADDR = 32'h10;
  localparam logic [DW-1:0] OFS_CFG   = 32'h20;
  localparam logic [DW-1:0] OFS_STAT  = 32'h24;
  localparam logic [DW-1:0] OFS_RFSH  = 32'h30;
  localparam logic [DW-1:0] OFS_PMT   = 32'h34;
  localparam logic [DW-1:0] OFS_BANK0 = 32'h40;
  localparam logic [DW-1:0] OFS_TMG   = 32'h80;
  localparam logic [DW-1:0] OFS_ECFG  = 32'h94;
  localparam logic [DW-1:0] OFS_EESR  = 32'h98;

  // writable-bit masks
  localparam logic [DW-1:0] MSK_RFSH = 32'h3FF8_0000;
  localparam logic [DW-1:0] MSK_TMG  = 32'h018F_C01F;
  localparam logic [DW-1:0] MSK_ECFG = 32'h00F0_0000;
  localparam logic [DW-1:0] MSK_BANK = 32'hFFDE_E001;
  localparam logic [DW-1:0] MSK_PMT  = 32'hF800_0000;
  localparam logic [DW-1:0] FIX_PMT  = 32'h07C0_0000;

  // reset values
  localparam logic [DW-1:0] RST_CFG  = 32'h0080_0000;
  localparam logic [DW-1:0] RST_RFSH = 32'h05F0_0000;
  localparam logic [DW-1:0] RST_PMT  = 32'h07C0_0000;
  localparam logic [DW-1:0] RST_TMG  = 32'h0085_4009;

  // control bit positions decoded by the status logic and bank mapping
  localparam int BIT_CTL_EN = 31;
  localparam int BIT_SR_REQ = 30;
endpackage

// File: rtl/sdrc_index_port.sv
module sdrc_index_port #(
  parameter int NUM_W   = 10,
  parameter int IDX_NUM = 'h010,
  parameter int DAT_NUM = 'h011
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_W-1:0]       bus_num,
  input  logic                   bus_wr,
  input  logic [sdrc_pkg::DW-1:0] bus_wdata,
  output logic                   sel_idx,
  output logic                   sel_dat,
  output logic                   dat_wr,
  output logic [sdrc_pkg::DW-1:0] idx_q
);
  localparam logic [NUM_W-1:0] IDX_N = NUM_W'(IDX_NUM);
  localparam logic [NUM_W-1:0] DAT_N = NUM_W'(DAT_NUM);

  assign sel_idx = (bus_num == IDX_N);
  assign sel_dat = (bus_num == DAT_N);
  assign dat_wr  = bus_wr && sel_dat;

  always_ff @(posedge clk) begin
    if (rst)                   idx_q <= '0;
    else if (bus_wr && sel_idx) idx_q <= bus_wdata;
  end
endmodule

// File: rtl/sdrc_ctrl_status.sv
module sdrc_ctrl_status (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_wr,
  input  logic [sdrc_pkg::DW-1:0] wdata,
  output logic [sdrc_pkg::DW-1:0] cfg_q,
  output logic [sdrc_pkg::DW-1:0] status_q
);
  import sdrc_pkg::*;

  logic en_up, en_dn, sr_up, sr_dn;

  always_comb begin
    en_up = cfg_wr && !cfg_q[BIT_CTL_EN] &&  wdata[BIT_CTL_EN];
    en_dn = cfg_wr &&  cfg_q[BIT_CTL_EN] && !wdata[BIT_CTL_EN];
    sr_up = cfg_wr && !cfg_q[BIT_SR_REQ] &&  wdata[BIT_SR_REQ];
    sr_dn = cfg_wr &&  cfg_q[BIT_SR_REQ] && !wdata[BIT_SR_REQ];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= RST_CFG;
      status_q <= '0;
    end else begin
      if (cfg_wr) cfg_q <= wdata;
      if (en_up)      status_q[BIT_CTL_EN] <= 1'b0;
      else if (en_dn) status_q[BIT_CTL_EN] <= 1'b1;
      if (sr_up)      status_q[BIT_SR_REQ] <= 1'b1;
      else if (sr_dn) status_q[BIT_SR_REQ] <= 1'b0;
    end
  end
endmodule

// File: rtl/sdrc_bank_cfg.sv
module sdrc_bank_cfg #(
  parameter int N_BANKS = 4
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 dat_wr,
  input  logic [sdrc_pkg::DW-1:0]              idx,
  input  logic [sdrc_pkg::DW-1:0]              wdata,
  input  logic                                 ctl_en,
  output logic [N_BANKS-1:0][sdrc_pkg::DW-1:0] bank_q,
  output logic [N_BANKS-1:0]                   active
);
  import sdrc_pkg::*;

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    localparam logic [DW-1:0] MY_OFS = OFS_BANK0 + DW'(4 * b);
    always_ff @(posedge clk) begin
      if (rst)                          bank_q[b] <= '0;
      else if (dat_wr && idx == MY_OFS) bank_q[b] <= wdata & MSK_BANK;
    end
    assign active[b] = ctl_en && bank_q[b][0];
  end
endmodule

// File: rtl/sdrc_cfg_regs.sv
module sdrc_cfg_regs #(
  parameter int NUM_W   = 10,
  parameter int IDX_NUM = 'h010,
  parameter int DAT_NUM = 'h011,
  parameter int N_BANKS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_W-1:0]   bus_num,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_rvalid,
  input  logic [31:0]        err_set0,
  input  logic [31:0]        err_set1,
  output logic [N_BANKS-1:0] bank_active,
  output logic               ecc_irq
);
  import sdrc_pkg::*;

  logic          sel_idx, sel_dat, dat_wr;
  logic [DW-1:0] idx_q;
  logic [DW-1:0] cfg_q, status_q;
  logic [N_BANKS-1:0][DW-1:0] bank_q;
  logic [DW-1:0] err0_q, err1_q, eaddr_q, rfsh_q, pmt_q, tmg_q, ecfg_q, eesr_q;
  logic [DW-1:0] eesr_d, rd_mux;

  sdrc_index_port #(.NUM_W(NUM_W), .IDX_NUM(IDX_NUM), .DAT_NUM(DAT_NUM)) u_idx (
    .clk(clk), .rst(rst), .bus_num(bus_num), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .sel_idx(sel_idx), .sel_dat(sel_dat),
    .dat_wr(dat_wr), .idx_q(idx_q));

  sdrc_ctrl_status u_ctl (
    .clk(clk), .rst(rst), .cfg_wr(dat_wr && idx_q == OFS_CFG),
    .wdata(bus_wdata), .cfg_q(cfg_q), .status_q(status_q));

  sdrc_bank_cfg #(.N_BANKS(N_BANKS)) u_bank (
    .clk(clk), .rst(rst), .dat_wr(dat_wr), .idx(idx_q), .wdata(bus_wdata),
    .ctl_en(cfg_q[BIT_CTL_EN]), .bank_q(bank_q), .active(bank_active));

  function automatic logic hit(input logic [DW-1:0] ofs);
    return dat_wr && (idx_q == ofs);
  endfunction

  assign eesr_d = hit(OFS_EESR) ? bus_wdata : eesr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      err0_q  <= '0;
      err1_q  <= '0;
      eaddr_q <= '0;
      rfsh_q  <= RST_RFSH;
      pmt_q   <= RST_PMT;
      tmg_q   <= RST_TMG;
      ecfg_q  <= '0;
      eesr_q  <= '0;
      ecc_irq <= 1'b0;
    end else begin
      // set pulses win over a same-cycle clear
      err0_q <= (err0_q & ~(hit(OFS_ERR0) ? bus_wdata : '0)) | err_set0;
      err1_q <= (err1_q & ~(hit(OFS_ERR1) ? bus_wdata : '0)) | err_set1;
      if (hit(OFS_EADDR)) eaddr_q <= bus_wdata;
      if (hit(OFS_RFSH))  rfsh_q  <= bus_wdata & MSK_RFSH;
      if (hit(OFS_PMT))   pmt_q   <= (bus_wdata & MSK_PMT) | FIX_PMT;
      if (hit(OFS_TMG))   tmg_q   <= bus_wdata & MSK_TMG;
      if (hit(OFS_ECFG))  ecfg_q  <= bus_wdata & MSK_ECFG;
      eesr_q  <= eesr_d;
      ecc_irq <= (eesr_d != '0);
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < N_BANKS; b++)
      if (idx_q == OFS_BANK0 + DW'(4 * b)) rd_mux = bank_q[b];
    case (idx_q)
      OFS_ERR0:  rd_mux = err0_q;
      OFS_ERR1:  rd_mux = err1_q;
      OFS_EADDR: rd_mux = eaddr_q;
      OFS_CFG:   rd_mux = cfg_q;
      OFS_STAT:  rd_mux = status_q;
      OFS_RFSH:  rd_mux = rfsh_q;
      OFS_PMT:   rd_mux = pmt_q;
      OFS_TMG:   rd_mux = tmg_q;
      OFS_ECFG:  rd_mux = ecfg_q;
      OFS_EESR:  rd_mux = eesr_q;
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd && (sel_idx || sel_dat);
      if (bus_rd && sel_idx)      bus_rdata <= idx_q;
      else if (bus_rd && sel_dat) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/sdrc_cfg_regs_chk.sv
module sdrc_cfg_regs_chk #(
  parameter int NUM_W   = 10,
  parameter int IDX_NUM = 'h010,
  parameter int DAT_NUM = 'h011,
  parameter int N_BANKS = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_W-1:0]   bus_num,
  input logic               bus_rd,
  input logic               bus_rvalid,
  input logic [31:0]        err_set0,
  input logic [31:0]        err0_q,
  input logic [31:0]        cfg_q,
  input logic [31:0]        status_q,
  input logic [31:0]        pmt_q,
  input logic [31:0]        eesr_q,
  input logic [N_BANKS-1:0] bank_active,
  input logic               ecc_irq
);
  // R12
  rvalid_due_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd && (bus_num == NUM_W'(IDX_NUM) || bus_num == NUM_W'(DAT_NUM)) |=> bus_rvalid);
  // R12
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);
  // R5
  err_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (err_set0 != '0) |=> ((err0_q & $past(err_set0)) == $past(err_set0)));
  // R7
  en_rise_stat_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_q[31]) |-> !status_q[31]);
  // R7
  en_fall_stat_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cfg_q[31]) |-> status_q[31]);
  // R8
  sr_rise_stat_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_q[30]) |-> status_q[30]);
  // R11
  bank_off_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_q[31] |-> (bank_active == '0));
  // R9
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    ecc_irq == (eesr_q != '0));
  // R4
  pmt_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    pmt_q[26:22] == 5'b11111);
endmodule

bind sdrc_cfg_regs sdrc_cfg_regs_chk #(
  .NUM_W(NUM_W), .IDX_NUM(IDX_NUM), .DAT_NUM(DAT_NUM), .N_BANKS(N_BANKS)
) u_chk (
  .clk(clk), .rst(rst), .bus_num(bus_num), .bus_rd(bus_rd),
  .bus_rvalid(bus_rvalid), .err_set0(err_set0), .err0_q(err0_q),
  .cfg_q(cfg_q), .status_q(status_q), .pmt_q(pmt_q), .eesr_q(eesr_q),
  .bank_active(bank_active), .ecc_irq(ecc_irq));

// File: tb/sdrc_cfg_regs_tb.sv
module sdrc_cfg_regs_tb;
  localparam int NUM_W = 10;
  localparam logic [NUM_W-1:0] IDX = 10'h010;
  localparam logic [NUM_W-1:0] DAT = 10'h011;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NUM_W-1:0] bus_num = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, err_set0 = '0, err_set1 = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid, ecc_irq;
  logic [3:0] bank_active;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sdrc_cfg_regs u_dut (
    .clk(clk), .rst(rst), .bus_num(bus_num), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .err_set0(err_set0), .err_set1(err_set1), .bank_active(bank_active),
    .ecc_irq(ecc_irq));

  // {req, offset, write value, expected readback}
  localparam int NV = 11;
  localparam logic [79:0] VEC [NV] = '{
    {8'd3,  8'h30, 32'hFFFF_FFFF, 32'h3FF8_0000},
    {8'd3,  8'h80, 32'hFFFF_FFFF, 32'h018F_C01F},
    {8'd3,  8'h94, 32'hFFFF_FFFF, 32'h00F0_0000},
    {8'd4,  8'h34, 32'hFFFF_FFFF, 32'hFFC0_0000},
    {8'd4,  8'h34, 32'h0000_0000, 32'h07C0_0000},
    {8'd3,  8'h40, 32'hFFFF_FFFF, 32'hFFDE_E001},
    {8'd3,  8'h4C, 32'h1234_5678, 32'h1214_4000},
    {8'd3,  8'h10, 32'hA5A5_A5A5, 32'hA5A5_A5A5},
    {8'd6,  8'h24, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'd10, 8'h50, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'd10, 8'hFC, 32'h0000_0001, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [NUM_W-1:0] num, input logic [31:0] d);
    @(negedge clk);
    bus_num = num; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [NUM_W-1:0] num, output logic [31:0] d, output logic v);
    @(negedge clk);
    bus_num = num; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata; v = bus_rvalid;
  endtask

  task automatic reg_write(input logic [31:0] ofs, input logic [31:0] d);
    bus_write(IDX, ofs);
    bus_write(DAT, d);
  endtask

  task automatic reg_read(input logic [31:0] ofs, output logic [31:0] d);
    logic v;
    bus_write(IDX, ofs);
    bus_read(DAT, d, v);
    chk("R12 data-port rvalid", 32'(v), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 bank_active", 32'(bank_active), 32'h0);
    chk("R1 ecc_irq", 32'(ecc_irq), 32'h0);
    reg_read(32'h20, d); chk("R1 cfg", d, 32'h0080_0000);
    reg_read(32'h30, d); chk("R1 refresh", d, 32'h05F0_0000);
    reg_read(32'h34, d); chk("R1 pm timer", d, 32'h07C0_0000);
    reg_read(32'h80, d); chk("R1 timing", d, 32'h0085_4009);
    reg_read(32'h24, d); chk("R1 status", d, 32'h0);
    reg_read(32'h98, d); chk("R1 ecc status", d, 32'h0);
    reg_read(32'h44, d); chk("R1 bank1", d, 32'h0);

    // R3 R4 R6 R10 vector table
    for (int i = 0; i < NV; i++) begin
      reg_write(32'(VEC[i][71:64]), VEC[i][63:32]);
      reg_read(32'(VEC[i][71:64]), d);
      chk($sformatf("R%0d vector %0d", VEC[i][79:72], i), d, VEC[i][31:0]);
    end
    // R10 unmapped write must not have touched neighbours
    reg_read(32'h4C, d); chk("R10 bank3 untouched", d, 32'h1214_4000);

    // R2 index port readback
    bus_write(IDX, 32'hDEAD_0098);
    bus_read(IDX, d, v);
    chk("R2 index readback", d, 32'hDEAD_0098);
    chk("R12 index rvalid", 32'(v), 32'd1);

    // R12 foreign register number: no rvalid, no state change
    bus_read(10'h012, d, v);
    chk("R12 foreign read rvalid", 32'(v), 32'd0);
    bus_write(10'h012, 32'h0000_0030);
    bus_read(IDX, d, v);
    chk("R12 foreign write ignored", d, 32'hDEAD_0098);

    // R7 R11 enable transitions
    reg_write(32'h20, 32'h8000_0000);
    chk("R11 bank0 active", 32'(bank_active), 32'h1);
    reg_read(32'h24, d); chk("R7 enable rise", d, 32'h0);
    reg_write(32'h20, 32'h0000_0000);
    chk("R11 banks off", 32'(bank_active), 32'h0);
    reg_read(32'h24, d); chk("R7 enable fall", d, 32'h8000_0000);
    // R8 self-refresh bit together with enable rise
    reg_write(32'h20, 32'hC000_0000);
    reg_read(32'h24, d); chk("R8 sr rise", d, 32'h4000_0000);
    reg_write(32'h20, 32'h8000_0000);
    reg_read(32'h24, d); chk("R8 sr fall", d, 32'h0);
    reg_write(32'h44, 32'h0000_0001);
    chk("R11 bank1 active", 32'(bank_active), 32'h3);

    // R5 error status set and write-one-to-clear
    @(negedge clk); err_set0 = 32'h0000_00F0; err_set1 = 32'h0F00_0000;
    @(negedge clk); err_set0 = '0; err_set1 = '0;
    reg_read(32'h00, d); chk("R5 err0 set", d, 32'h0000_00F0);
    reg_write(32'h00, 32'h0000_0030);
    reg_read(32'h00, d); chk("R5 err0 w1c", d, 32'h0000_00C0);
    reg_read(32'h08, d); chk("R5 err1 set", d, 32'h0F00_0000);
    // R5 set wins over same-cycle clear
    bus_write(IDX, 32'h08);
    @(negedge clk);
    bus_num = DAT; bus_wdata = 32'h0F00_0000; bus_wr = 1'b1; err_set1 = 32'h0100_0000;
    @(negedge clk);
    bus_wr = 1'b0; err_set1 = '0;
    reg_read(32'h08, d); chk("R5 set wins", d, 32'h0100_0000);

    // R9 ecc interrupt
    reg_write(32'h98, 32'h0000_0005);
    chk("R9 irq rise", 32'(ecc_irq), 32'd1);
    reg_write(32'h98, 32'h0000_0100);
    chk("R9 irq stays", 32'(ecc_irq), 32'd1);
    reg_write(32'h98, 32'h0);
    chk("R9 irq fall", 32'(ecc_irq), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule